// File: doc/BRIEF.md
# Two-Wire Target Register Bank with Wrapping Pointer

This block is the serial front end of a small timekeeping chip. It listens on a two-wire I2C bus as a target. It holds twenty byte-wide registers behind a single address pointer. The bus clock and data lines first pass through a two-flop synchronizer, and then through edge detection in the system clock domain. START and STOP are recognised from data transitions while the clock line is high. The block compares the 7-bit target address and follows the direction bit. After each byte it acknowledges by holding the data line low for the ninth clock.

In a write transfer, the first byte after the address loads the pointer and later bytes are data. In a read transfer, bytes are shifted out most significant bit first. The pointer advances after every data byte in both directions. It runs from 00h to 13h and then returns to 00h. Writing the value 58h to register 00h is not stored: it resets the whole bank, the same as a power-on reset. The timekeeping logic sees every register in parallel, together with single-cycle write and read strobes per register.

The data line drive is an open-drain enable: a 1 pulls the line low. The block has no valid/ready stream at its edge. Pacing comes entirely from the bus clock, so the strobes and the reset pulse are plain single-cycle signals that the consumer cannot stall.

Top module: `clkreg_i2c_target`

## Requirements
- R1: After reset every register reads 00h, the pointer is 00h and the data line is not driven.
- R2: An address byte whose upper seven bits equal the target address (default 68h) is acknowledged. Any other address is not acknowledged, and the block then neither drives the line nor changes any register until the next START or STOP.
- R3: In a write transfer the first byte after the address loads the pointer and is acknowledged. A pointer value above 13h loads 00h.
- R4: Each later write byte is acknowledged and stored at the pointer. Its bit g of `wr_stb` pulses for one cycle, and the pointer then advances, with 13h followed by 00h.
- R5: In a read transfer, the byte at the pointer is shifted out MSB first and its bit of `rd_stb` pulses when it is fetched. The pointer advances after each byte, with the same wrap.
- R6: When the controller does not acknowledge a read byte, the block releases the line and drives nothing until the next START or STOP.
- R7: A repeated START ends a write transfer and keeps the pointer, so a pointer write followed by a repeated START and a read returns the addressed register.
- R8: Unimplemented bits are stored and read as 0. Register 04h keeps only bits 5:0 and register 07h only bits 2:0; all other registers keep all eight bits.
- R9: A write of 58h to register 00h clears every register to 00h and sets the pointer to 00h. It raises `sw_rst` for one cycle and raises no write strobe. The same value written to any other register is stored normally.
- R10: The pointer persists across transfers: a read with no pointer byte starts where the previous transfer left it.
- R11: The block only begins driving the data line while the bus clock is low, and never changes its drive during a stretch of high bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_q | output | NREG*8 | All registers, register g at bits g*8+7:g*8 |
| wr_stb | output | NREG | One-cycle pulse on the register being written |
| rd_stb | output | NREG | One-cycle pulse on the register being fetched for reading |
| sw_rst | output | 1 | One-cycle pulse on a software reset |

## Verification
The bench sweeps every starting pointer with three-byte write bursts and set-pointer-then-read bursts. This covers the wrap at 13h: a design wrapping at a power of two would land bytes in the wrong registers or read back stale data. A full 21-byte read, a read continued across a STOP, and an out-of-range pointer byte exercise pointer persistence and clamping. A wrong address, and bus clocks after a read NACK, check that the block stays silent; a design that kept driving would corrupt bits the controller reads. The reset code goes both to register 00h, where it must clear the bank and reset the pointer so that the next byte lands in 00h, and to register 01h, where it must be stored.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/clkreg_line_sync.sv
module clkreg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/clkreg_store.sv
module clkreg_store #(
  parameter int NREG = 20,
  parameter int DW = 8,
  parameter int NARROW_A_IDX = 4,
  parameter logic [DW-1:0] NARROW_A_MASK = 8'h3F,
  parameter int NARROW_B_IDX = 7,
  parameter logic [DW-1:0] NARROW_B_MASK = 8'h07,
  localparam int PW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic               clr,
  output logic [NREG*DW-1:0] q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] KEEP = (g == NARROW_A_IDX) ? NARROW_A_MASK :
                                     (g == NARROW_B_IDX) ? NARROW_B_MASK : '1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g*DW +: DW] <= '0;
      end else if (clr) begin
        q[g*DW +: DW] <= '0;
      end else if (wr_en && (wr_idx == PW'(g))) begin
        q[g*DW +: DW] <= wr_data & KEEP;
      end
    end
  end
endmodule

// File: rtl/clkreg_engine.sv
module clkreg_engine
  import clkreg_pkg::*;
#(
  parameter int NREG = 20,
  parameter int DW = 8,
  parameter int AW = 7,
  parameter logic [AW-1:0] DEV_ADDR = 7'h68,
  parameter logic [DW-1:0] SWRST_CODE = 8'h58,
  localparam int PW = $clog2(NREG),
  localparam int CW = $clog2(DW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [NREG*DW-1:0] bank_q,
  output logic               sda_oe,
  output logic               wr_en,
  output logic [PW-1:0]      wr_idx,
  output logic [DW-1:0]      wr_data,
  output logic               rd_en,
  output logic [PW-1:0]      rd_idx,
  output logic               clr
);
  phase_t        ph;
  logic          ack_ph;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [PW-1:0] ptr;
  logic          dir_rd;
  logic          host_ack;
  logic [DW-1:0] cur_byte;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(NREG - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cur_byte = bank_q[int'(ptr)*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      ack_ph   <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      ptr      <= '0;
      dir_rd   <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      rd_en    <= 1'b0;
      rd_idx   <= '0;
      clr      <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      clr   <= 1'b0;
      if (start_det) begin
        ph     <= PH_ADDR;
        ack_ph <= 1'b0;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        ph     <= PH_IDLE;
        ack_ph <= 1'b0;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (ph)
          PH_IDLE, PH_SKIP: sda_oe <= 1'b0;
          PH_ADDR, PH_PTR, PH_WDATA: begin
            if (!ack_ph) begin
              if (scl_rise && cnt < CW'(DW)) begin
                sh  <= {sh[DW-2:0], sda_s};
                cnt <= cnt + 1'b1;
              end else if (scl_fall && cnt == CW'(DW)) begin
                cnt    <= '0;
                ack_ph <= 1'b1;
                if (ph == PH_ADDR) begin
                  if (sh[DW-1:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1;
                    dir_rd <= sh[0];
                  end else begin
                    ph <= PH_SKIP;
                  end
                end else if (ph == PH_PTR) begin
                  ptr    <= (int'(sh) < NREG) ? sh[PW-1:0] : '0;
                  sda_oe <= 1'b1;
                end else begin
                  sda_oe <= 1'b1;
                  if (ptr == '0 && sh == SWRST_CODE) begin
                    clr <= 1'b1;
                    ptr <= '0;
                  end else begin
                    wr_en   <= 1'b1;
                    wr_idx  <= ptr;
                    wr_data <= sh;
                    ptr     <= bump(ptr);
                  end
                end
              end
            end else if (scl_fall) begin
              ack_ph <= 1'b0;
              sda_oe <= 1'b0;
              if (ph == PH_ADDR) begin
                if (dir_rd) begin
                  ph     <= PH_RDATA;
                  sh     <= cur_byte;
                  sda_oe <= ~cur_byte[DW-1];
                  rd_en  <= 1'b1;
                  rd_idx <= ptr;
                end else begin
                  ph <= PH_PTR;
                end
              end else if (ph == PH_PTR) begin
                ph <= PH_WDATA;
              end
            end
          end
          PH_RDATA: begin
            if (!ack_ph) begin
              if (scl_rise && cnt < CW'(DW)) begin
                cnt <= cnt + 1'b1;
              end else if (scl_fall) begin
                if (cnt == CW'(DW)) begin
                  sda_oe <= 1'b0;
                  ack_ph <= 1'b1;
                  cnt    <= '0;
                  ptr    <= bump(ptr);
                end else begin
                  sh     <= {sh[DW-2:0], 1'b0};
                  sda_oe <= ~sh[DW-2];
                end
              end
            end else begin
              if (scl_rise) begin
                host_ack <= ~sda_s;
              end else if (scl_fall) begin
                ack_ph <= 1'b0;
                if (host_ack) begin
                  sh     <= cur_byte;
                  sda_oe <= ~cur_byte[DW-1];
                  rd_en  <= 1'b1;
                  rd_idx <= ptr;
                end else begin
                  ph     <= PH_SKIP;
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkreg_i2c_target.sv
module clkreg_i2c_target #(
  parameter int NREG = 20,
  parameter int DW = 8,
  parameter int AW = 7,
  parameter logic [AW-1:0] DEV_ADDR = 7'h68,
  parameter logic [DW-1:0] SWRST_CODE = 8'h58,
  parameter int SYNC_STAGES = 2,
  parameter int NARROW_A_IDX = 4,
  parameter logic [DW-1:0] NARROW_A_MASK = 8'h3F,
  parameter int NARROW_B_IDX = 7,
  parameter logic [DW-1:0] NARROW_B_MASK = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] reg_q,
  output logic [NREG-1:0]    wr_stb,
  output logic [NREG-1:0]    rd_stb,
  output logic               sw_rst
);
  localparam int PW = $clog2(NREG);

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en, rd_en, clr;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [DW-1:0] wr_data;

  clkreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkreg_engine #(
    .NREG(NREG), .DW(DW), .AW(AW), .DEV_ADDR(DEV_ADDR), .SWRST_CODE(SWRST_CODE)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .bank_q(reg_q), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx), .clr(clr)
  );

  clkreg_store #(
    .NREG(NREG), .DW(DW),
    .NARROW_A_IDX(NARROW_A_IDX), .NARROW_A_MASK(NARROW_A_MASK),
    .NARROW_B_IDX(NARROW_B_IDX), .NARROW_B_MASK(NARROW_B_MASK)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .clr(clr), .q(reg_q)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_stb
    assign wr_stb[g] = wr_en && (wr_idx == PW'(g));
    assign rd_stb[g] = rd_en && (rd_idx == PW'(g));
  end

  assign sw_rst = clr;
endmodule

// File: rtl/clkreg_i2c_target_chk.sv
module clkreg_i2c_target_chk #(
  parameter int NREG = 20,
  parameter int DW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_in,
  input logic               sda_oe,
  input logic [NREG*DW-1:0] reg_q,
  input logic [NREG-1:0]    wr_stb,
  input logic [NREG-1:0]    rd_stb,
  input logic               sw_rst
);
  a_r4_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));
  a_r5_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_stb));
  a_r9_no_store_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |-> (wr_stb == '0));
  a_r9_bank_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (reg_q == '0));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !sw_rst);
  a_r11_drive_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);
  a_r11_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && $past(scl_in) && $past(scl_in, 2) && $past(scl_in, 3)) |-> $stable(sda_oe));
endmodule

bind clkreg_i2c_target clkreg_i2c_target_chk #(.NREG(NREG), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .reg_q(reg_q), .wr_stb(wr_stb), .rd_stb(rd_stb), .sw_rst(sw_rst)
);

// File: tb/clkreg_i2c_target_tb_top.sv
module clkreg_i2c_target_tb_top;
  localparam int NREG = 20;
  localparam logic [6:0] ADDR = 7'h68;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic ctl_low = 1'b0;
  logic dut_oe;
  logic sda;
  logic [NREG*8-1:0] reg_q;
  logic [NREG-1:0] wr_stb, rd_stb;
  logic sw_rst;

  assign sda = ~(ctl_low | dut_oe);
  always #4 clk = ~clk;

  clkreg_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .sda_oe(dut_oe),
    .reg_q(reg_q), .wr_stb(wr_stb), .rd_stb(rd_stb), .sw_rst(sw_rst)
  );

  int total = 0, bad = 0;
  int wr_cnt = 0, last_wr = -1, rd_cnt = 0, rst_cnt = 0;
  int high_rise = 0, quiet_drive = 0;
  logic quiet = 1'b0, oe_prev = 1'b0;
  logic [7:0] model [NREG];
  int mptr = 0;

  always @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (wr_stb[i]) begin wr_cnt++; last_wr = i; end
      if (rd_stb[i]) rd_cnt++;
    end
    if (sw_rst) rst_cnt++;
    if (dut_oe && !oe_prev && scl) high_rise++;
    if (quiet && dut_oe) quiet_drive++;
    oe_prev <= dut_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] keep(input int i);
    return (i == 4) ? 8'h3F : (i == 7) ? 8'h07 : 8'hFF;
  endfunction

  task automatic mwrite(input logic [7:0] d);
    if (mptr == 0 && d == 8'h58) begin
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      mptr = 0;
    end else begin
      model[mptr] = d & keep(mptr);
      mptr = (mptr + 1) % NREG;
    end
  endtask

  task automatic hp(); repeat (6) @(negedge clk); endtask

  task automatic bus_start();
    hp(); ctl_low = 1'b0; hp(); scl = 1'b1; hp(); ctl_low = 1'b1; hp(); scl = 1'b0; hp();
  endtask

  task automatic bus_stop();
    hp(); ctl_low = 1'b1; hp(); scl = 1'b1; hp(); ctl_low = 1'b0; hp();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      hp(); ctl_low = ~b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    hp(); ctl_low = 1'b0; hp(); scl = 1'b1; hp(); ackd = ~sda; scl = 1'b0;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hp(); ctl_low = 1'b0; hp(); scl = 1'b1; hp(); b[i] = sda; scl = 1'b0;
    end
    hp(); ctl_low = give_ack; hp(); scl = 1'b1; hp(); scl = 1'b0;
    hp(); ctl_low = 1'b0;
  endtask

  task automatic write_burst(input logic [7:0] p, input int n, input logic [7:0] base);
    logic a;
    bus_start();
    put_byte({ADDR, 1'b0}, a); chk("R2 address ack", 32'(a), 1);
    put_byte(p, a); chk("R3 pointer ack", 32'(a), 1);
    mptr = (int'(p) < NREG) ? int'(p) : 0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      int idx;
      d = base + 8'(k * 29);
      idx = mptr;
      put_byte(d, a); chk("R4 data ack", 32'(a), 1);
      if (!(idx == 0 && d == 8'h58)) chk("R4 strobe index", 32'(last_wr), 32'(idx));
      mwrite(d);
    end
    bus_stop();
  endtask

  task automatic read_run(input int n, input logic set_p, input logic [7:0] p);
    logic a;
    logic [7:0] got;
    bus_start();
    if (set_p) begin
      put_byte({ADDR, 1'b0}, a); chk("R7 address ack", 32'(a), 1);
      put_byte(p, a); chk("R7 pointer ack", 32'(a), 1);
      mptr = int'(p);
      bus_start();
    end
    put_byte({ADDR, 1'b1}, a); chk("R5 read address ack", 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, got);
      chk("R5 read byte", 32'(got), 32'(model[mptr]));
      mptr = (mptr + 1) % NREG;
    end
    bus_stop();
  endtask

  task automatic cmp_bank(input string req);
    for (int i = 0; i < NREG; i++) chk(req, 32'(reg_q[i*8 +: 8]), 32'(model[i]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] got;
    int w0, r0;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 bank after reset", 32'(reg_q == '0), 1);
    chk("R1 line released", 32'(dut_oe), 0);

    // R4 R5 R7 R8: sweep every start pointer
    for (int p = 0; p < NREG; p++) begin
      w0 = wr_cnt;
      write_burst(8'(p), 3, 8'(p * 7 + 1));
      chk("R4 strobe count", 32'(wr_cnt - w0), 3);
      cmp_bank("R4 parallel output");
      r0 = rd_cnt;
      read_run(3, 1'b1, 8'(p));
      chk("R5 fetch strobes", 32'(rd_cnt - r0), 3);
    end

    // R8: unimplemented bits
    write_burst(8'h04, 1, 8'hFF);
    write_burst(8'h07, 1, 8'hFF);
    chk("R8 reg04 masked", 32'(reg_q[4*8 +: 8]), 32'h3F);
    chk("R8 reg07 masked", 32'(reg_q[7*8 +: 8]), 32'h07);

    // R5: full wrap read, R10: continue across transfers
    read_run(21, 1'b1, 8'h00);
    read_run(2, 1'b1, 8'h05);
    read_run(2, 1'b0, 8'h00);

    // R3: out-of-range pointer clamps to 00h
    write_burst(8'h30, 1, 8'h11);
    chk("R3 clamped pointer", 32'(reg_q[7:0]), 32'h11);

    // R2: wrong address ignored
    w0 = wr_cnt;
    bus_start();
    quiet = 1'b1;
    put_byte({7'h21, 1'b0}, a);
    chk("R2 foreign address nack", 32'(a), 0);
    put_byte(8'h02, a);
    put_byte(8'hEE, a);
    quiet = 1'b0;
    bus_stop();
    chk("R2 no write on foreign", 32'(wr_cnt - w0), 0);
    chk("R2 no line drive", 32'(quiet_drive), 0);
    cmp_bank("R2 bank unchanged");

    // R6: NACK releases the line
    bus_start();
    put_byte({ADDR, 1'b1}, a);
    get_byte(1'b0, got);
    mptr = (mptr + 1) % NREG;
    quiet = 1'b1;
    for (int k = 0; k < 9; k++) begin
      hp(); ctl_low = 1'b0; hp(); scl = 1'b1; hp();
      chk("R6 released after nack", 32'(sda), 1);
      scl = 1'b0;
    end
    quiet = 1'b0;
    bus_stop();
    chk("R6 no drive after nack", 32'(quiet_drive), 0);

    // R9: reset code at a non-zero register is plain data
    write_burst(8'h01, 1, 8'h58);
    chk("R9 code stored elsewhere", 32'(reg_q[15:8]), 32'h58);
    chk("R9 no pulse elsewhere", 32'(rst_cnt), 0);

    // R9: reset code at register 00h, next byte lands at 00h
    w0 = wr_cnt;
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h00, a);
    mptr = 0;
    put_byte(8'h58, a); mwrite(8'h58);
    chk("R9 reset pulse", 32'(rst_cnt), 1);
    chk("R9 bank cleared", 32'(reg_q == '0), 1);
    chk("R9 no write strobe", 32'(wr_cnt - w0), 0);
    put_byte(8'hA5, a); mwrite(8'hA5);
    bus_stop();
    chk("R9 pointer back at 00h", 32'(reg_q[7:0]), 32'hA5);
    cmp_bank("R9 bank after reset");

    // R11: never started driving with clock high
    chk("R11 drive start with clock high", 32'(high_rise), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule